// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register File

This block is the register file that software uses to steer a descriptor-driven DMA engine. It sits on a 32-bit memory-mapped slave port with five word registers. The first is a status word that mixes live engine flags with sticky event flags that software clears by writing 1. The second is a control word with stop, soft-reset, stop-on-event and interrupt-enable bits. The other three are read-only views of the FIFO fill levels and the two sequence counters.

Towards the engine it drives a stop line, a descriptor-hold line and a soft-reset line, and it raises one interrupt. The soft-reset line runs for a fixed number of cycles, and software watches it through a status flag. The engine reports to the block when it is busy, when a descriptor completes and asks for an interrupt, when an error or an early termination occurs, when a read or write descriptor finishes, and what its FIFO levels and empty/full flags are. Reads are combinational from the address; writes take effect at the clock edge on which the write strobe is high.

Top module: `dma_csr_block`

## Requirements
- R1: After the hardware reset, the control word reads 0, the sticky flags and both sequence counters read 0, and irqOut, engStop and engReset are low.
- R2: The address decode uses addr[4:2] as the word index. Word 0 is status and word 2 is {wrFill, rdFill}. Word 3 is respFill in bits 15:0, and word 4 is {wrSeq, rdSeq}. The status word shows five live inputs: engBusy in bit 0, descEmpty in bit 1, descFull in bit 2, respEmpty in bit 3 and respFull in bit 4.
- R3: Word 1 is control. The writable bits are stop (bit 0), stop-on-error (bit 2), stop-on-early (bit 3), interrupt enable (bit 4) and descriptor hold (bit 5), and they read back as written. Bit 1 always reads 0. engStop follows bit 0, descHold follows bit 5, and status bit 5 (stopped) equals engStop.
- R4: A control write with bit 1 set drives engReset and status bit 6 high from the next cycle, for exactly RST_CYCLES cycles. This clears the control word and both sequence counters.
- R5: While the soft reset runs, control writes are ignored and the control word stays 0.
- R6: A doneIrqReq pulse sets status bit 9. irqOut is high exactly when bit 9 and the interrupt enable are both set.
- R7: Writing 1 to status bits 7, 8 or 9 clears that flag. Writing 0 leaves it unchanged. The live bits 0 to 6 ignore status writes.
- R8: An errEvt pulse with stop-on-error set latches status bit 7 and raises engStop until bit 7 is cleared. Without the enable, an errEvt pulse changes nothing.
- R9: An earlyEvt pulse with stop-on-early set latches status bit 8 and raises engStop. Without the enable, an earlyEvt pulse changes nothing.
- R10: rdSeq counts rdDone pulses and wrSeq counts wrDone pulses. Pulses that arrive during a soft reset are not counted.
- R11: If a flag is set and cleared by write-1 in the same cycle, it ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| engBusy | input | 1 | Engine is moving data |
| descEmpty | input | 1 | Descriptor FIFO empty |
| descFull | input | 1 | Descriptor FIFO full |
| respEmpty | input | 1 | Response FIFO empty |
| respFull | input | 1 | Response FIFO full |
| rdFill | input | 16 | Read descriptor FIFO level |
| wrFill | input | 16 | Write descriptor FIFO level |
| respFill | input | 16 | Response FIFO level |
| rdDone | input | 1 | Read engine finished a descriptor |
| wrDone | input | 1 | Write engine finished a descriptor |
| doneIrqReq | input | 1 | Completed descriptor asked for an interrupt |
| errEvt | input | 1 | Engine reported an error |
| earlyEvt | input | 1 | Engine reported an early termination |
| engStop | output | 1 | Halt request to the engine |
| descHold | output | 1 | Stop taking new descriptors |
| engReset | output | 1 | Soft reset to the engine |
| irqOut | output | 1 | Interrupt line |

## Verification
The bench builds the block with RST_CYCLES set to 6 and the default 32-bit data width. With this setting the soft-reset window can be counted exactly, and a control write and a completion pulse can be placed inside it and shown to have no effect. The full 16-bit fill and sequence fields are exercised with distinct high and low half patterns, so a swapped half shows up. Same-cycle set and clear of the interrupt flag checks the set-over-clear rule.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // word index of each register (addr[4:2])
  localparam int IDX_STAT = 0;
  localparam int IDX_CTL  = 1;
  localparam int IDX_FILL = 2;
  localparam int IDX_RESP = 3;
  localparam int IDX_SEQ  = 4;

  // status bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_DEMPTY  = 1;
  localparam int ST_DFULL   = 2;
  localparam int ST_REMPTY  = 3;
  localparam int ST_RFULL   = 4;
  localparam int ST_STOPPED = 5;
  localparam int ST_RESET   = 6;
  localparam int ST_ERR     = 7;
  localparam int ST_EARLY   = 8;
  localparam int ST_IRQ     = 9;
  localparam int STAT_W     = 10;

  // control bit positions
  localparam int CT_STOP   = 0;
  localparam int CT_RESET  = 1;
  localparam int CT_ONERR  = 2;
  localparam int CT_ONEARLY= 3;
  localparam int CT_GIE    = 4;
  localparam int CT_HOLD   = 5;
  localparam int CTL_W     = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic       ctlWr;
    logic       ctlClr;
    logic [2:0] stickyClr;  // [0] error, [1] early, [2] irq
    logic       irqSet;
    logic       errSet;
    logic       earlySet;
    logic       seqClr;
    logic       rdInc;
    logic       wrInc;
  } csrStrobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrReset,
  input  logic [2:0]        wrSticky,
  input  logic              onErr,
  input  logic              onEarly,
  input  logic              doneIrqReq,
  input  logic              errEvt,
  input  logic              earlyEvt,
  input  logic              rdDone,
  input  logic              wrDone,
  output csrStrobe_t        strb,
  output logic              resetting
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int CNT_W  = $clog2(RST_CYCLES + 1);

  logic [WIDX_W-1:0] wordIdx;
  logic              isStat, isCtl, startReset;
  logic [CNT_W-1:0]  rstCnt;

  assign wordIdx    = addr[ADDR_W-1:2];
  assign isStat     = (wordIdx == WIDX_W'(IDX_STAT));
  assign isCtl      = (wordIdx == WIDX_W'(IDX_CTL));
  assign startReset = wrEn && isCtl && !resetting && wrReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetting <= 1'b0;
      rstCnt    <= '0;
    end else if (startReset) begin
      resetting <= 1'b1;
      rstCnt    <= CNT_W'(RST_CYCLES - 1);
    end else if (resetting) begin
      if (rstCnt == '0) resetting <= 1'b0;
      else              rstCnt    <= rstCnt - 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.ctlWr     = wrEn && isCtl && !resetting && !wrReset;
    strb.ctlClr    = resetting || startReset;
    strb.stickyClr = (wrEn && isStat) ? wrSticky : 3'b000;
    strb.irqSet    = doneIrqReq;
    strb.errSet    = errEvt && onErr;
    strb.earlySet  = earlyEvt && onEarly;
    strb.seqClr    = resetting || startReset;
    strb.rdInc     = rdDone && !strb.seqClr;
    strb.wrInc     = wrDone && !strb.seqClr;
  end

  // checker counter: length of the soft-reset window
  logic [CNT_W:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiCnt <= '0;
    else if (resetting) hiCnt <= hiCnt + 1'b1;
    else                hiCnt <= '0;
  end

  // R4
  reset_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReset |=> resetting);
  // R4
  reset_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetting) |-> (hiCnt == (CNT_W+1)'(RST_CYCLES)));
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  wrCtl,
  input  csrStrobe_t        strb,
  input  logic              resetting,
  input  logic              engBusy,
  input  logic              descEmpty,
  input  logic              descFull,
  input  logic              respEmpty,
  input  logic              respFull,
  input  logic [DATA_W/2-1:0] rdFill,
  input  logic [DATA_W/2-1:0] wrFill,
  input  logic [DATA_W/2-1:0] respFill,
  output logic [DATA_W-1:0] rdData,
  output logic [CTL_W-1:0]  ctlBits,
  output logic              stoppedErr,
  output logic              stoppedEarly,
  output logic              engStop,
  output logic              descHold,
  output logic              irqOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [CTL_W-1:0] CTL_MASK = ~(CTL_W'(1) << CT_RESET);

  logic [CTL_W-1:0]  ctlReg;
  logic              irqFlag;
  logic [HALF_W-1:0] rdSeq, wrSeq;
  logic [STAT_W-1:0] statusWord;
  logic [WIDX_W-1:0] wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctlReg <= '0;
    else if (strb.ctlClr)  ctlReg <= '0;
    else if (strb.ctlWr)   ctlReg <= wrCtl & CTL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stoppedErr   <= 1'b0;
      stoppedEarly <= 1'b0;
      irqFlag      <= 1'b0;
    end else begin
      stoppedErr   <= (stoppedErr   && !strb.stickyClr[0]) || strb.errSet;
      stoppedEarly <= (stoppedEarly && !strb.stickyClr[1]) || strb.earlySet;
      irqFlag      <= (irqFlag      && !strb.stickyClr[2]) || strb.irqSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSeq <= '0;
      wrSeq <= '0;
    end else if (strb.seqClr) begin
      rdSeq <= '0;
      wrSeq <= '0;
    end else begin
      if (strb.rdInc) rdSeq <= rdSeq + 1'b1;
      if (strb.wrInc) wrSeq <= wrSeq + 1'b1;
    end
  end

  assign ctlBits  = ctlReg;
  assign engStop  = ctlReg[CT_STOP] || stoppedErr || stoppedEarly;
  assign descHold = ctlReg[CT_HOLD];
  assign irqOut   = irqFlag && ctlReg[CT_GIE];

  always_comb begin
    statusWord              = '0;
    statusWord[ST_BUSY]     = engBusy;
    statusWord[ST_DEMPTY]   = descEmpty;
    statusWord[ST_DFULL]    = descFull;
    statusWord[ST_REMPTY]   = respEmpty;
    statusWord[ST_RFULL]    = respFull;
    statusWord[ST_STOPPED]  = engStop;
    statusWord[ST_RESET]    = resetting;
    statusWord[ST_ERR]      = stoppedErr;
    statusWord[ST_EARLY]    = stoppedEarly;
    statusWord[ST_IRQ]      = irqFlag;
  end

  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    case (wordIdx)
      WIDX_W'(IDX_STAT): rdData = DATA_W'(statusWord);
      WIDX_W'(IDX_CTL):  rdData = DATA_W'(ctlReg);
      WIDX_W'(IDX_FILL): rdData = {wrFill, rdFill};
      WIDX_W'(IDX_RESP): rdData = {{HALF_W{1'b0}}, respFill};
      WIDX_W'(IDX_SEQ):  rdData = {wrSeq, rdSeq};
      default:           rdData = '0;
    endcase
  end

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqSet |=> irqFlag);
  // R4
  seq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqClr |=> (rdSeq == '0 && wrSeq == '0));
  // R10
  rd_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdInc && !strb.seqClr) |=> (rdSeq == HALF_W'($past(rdSeq) + 1'b1)));
endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                engBusy,
  input  logic                descEmpty,
  input  logic                descFull,
  input  logic                respEmpty,
  input  logic                respFull,
  input  logic [DATA_W/2-1:0] rdFill,
  input  logic [DATA_W/2-1:0] wrFill,
  input  logic [DATA_W/2-1:0] respFill,
  input  logic                rdDone,
  input  logic                wrDone,
  input  logic                doneIrqReq,
  input  logic                errEvt,
  input  logic                earlyEvt,
  output logic                engStop,
  output logic                descHold,
  output logic                engReset,
  output logic                irqOut
);
  csrStrobe_t       strb;
  logic             resetting;
  logic [CTL_W-1:0] ctlBits;
  logic             stoppedErr, stoppedEarly;
  logic             unusedBits;

  assign unusedBits = ^{wrData[DATA_W-1:STAT_W], wrData[CTL_W], addr[1:0]};
  assign engReset   = resetting;

  csr_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrReset(wrData[CT_RESET]), .wrSticky(wrData[ST_IRQ:ST_ERR]),
    .onErr(ctlBits[CT_ONERR]), .onEarly(ctlBits[CT_ONEARLY]),
    .doneIrqReq(doneIrqReq), .errEvt(errEvt), .earlyEvt(earlyEvt),
    .rdDone(rdDone), .wrDone(wrDone), .strb(strb), .resetting(resetting)
  );

  csr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrCtl(wrData[CTL_W-1:0]),
    .strb(strb), .resetting(resetting), .engBusy(engBusy),
    .descEmpty(descEmpty), .descFull(descFull), .respEmpty(respEmpty),
    .respFull(respFull), .rdFill(rdFill), .wrFill(wrFill),
    .respFill(respFill), .rdData(rdData), .ctlBits(ctlBits),
    .stoppedErr(stoppedErr), .stoppedEarly(stoppedEarly),
    .engStop(engStop), .descHold(descHold), .irqOut(irqOut)
  );

  // R5
  ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetting |-> (ctlBits == '0));
  // R8
  err_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt && ctlBits[CT_ONERR]) |=> (stoppedErr && engStop));
  // R9
  early_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (earlyEvt && ctlBits[CT_ONEARLY]) |=> (stoppedEarly && engStop));
endmodule

// File: tb/tb_dma_csr_block.sv
module tb_dma_csr_block;
  localparam int CLK_PERIOD = 10;
  localparam int RST_N      = 6;
  localparam logic [4:0] A_STAT = 5'h00, A_CTL = 5'h04, A_FILL = 5'h08,
                         A_RESP = 5'h0C, A_SEQ = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic engBusy = 0, descEmpty = 0, descFull = 0, respEmpty = 0, respFull = 0;
  logic [15:0] rdFill = '0, wrFill = '0, respFill = '0;
  logic rdDone = 0, wrDone = 0, doneIrqReq = 0, errEvt = 0, earlyEvt = 0;
  logic engStop, descHold, engReset, irqOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_block #(.RST_CYCLES(RST_N)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .engBusy(engBusy), .descEmpty(descEmpty),
    .descFull(descFull), .respEmpty(respEmpty), .respFull(respFull),
    .rdFill(rdFill), .wrFill(wrFill), .respFill(respFill),
    .rdDone(rdDone), .wrDone(wrDone), .doneIrqReq(doneIrqReq),
    .errEvt(errEvt), .earlyEvt(earlyEvt), .engStop(engStop),
    .descHold(descHold), .engReset(engReset), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    busRead(A_CTL, v);  chk("R1 ctl", v, 0);
    busRead(A_STAT, v); chk("R1 status", v, 0);
    busRead(A_SEQ, v);  chk("R1 seq", v, 0);
    chk("R1 outs", {28'b0, irqOut, engStop, engReset, descHold}, 0);
  endtask

  task automatic testLive();
    logic [31:0] v;
    @(negedge clk);
    engBusy = 1; descFull = 1; respEmpty = 1;
    rdFill = 16'h1234; wrFill = 16'hABCD; respFill = 16'h0042;
    busRead(A_STAT, v); chk("R2 status pattern A", v, 32'h00D);
    busRead(A_FILL, v); chk("R2 fill word", v, 32'hABCD1234);
    busRead(A_RESP, v); chk("R2 resp fill", v, 32'h42);
    busWrite(A_STAT, 32'h3FF);
    busRead(A_STAT, v); chk("R7 live bits ignore write", v, 32'h00D);
    engBusy = 0; descFull = 0; respEmpty = 0; descEmpty = 1; respFull = 1;
    rdFill = 16'h00FF; wrFill = 16'h8001; respFill = 16'hFFFF;
    busRead(A_STAT, v); chk("R2 status pattern B", v, 32'h012);
    busRead(A_FILL, v); chk("R2 fill word B", v, 32'h800100FF);
    busRead(A_RESP, v); chk("R2 resp fill B", v, 32'hFFFF);
    descEmpty = 0; respFull = 0;
  endtask

  task automatic testCtl();
    logic [31:0] v;
    busWrite(A_CTL, 32'h3D);
    busRead(A_CTL, v);  chk("R3 ctl readback", v, 32'h3D);
    chk("R3 engStop/descHold", {30'b0, engStop, descHold}, 2'b11);
    busRead(A_STAT, v); chk("R3 stopped flag", v, 32'h020);
    busWrite(A_CTL, 32'h0);
    chk("R3 engStop released", {31'b0, engStop}, 0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    busWrite(A_CTL, 32'h10);
    @(negedge clk); doneIrqReq = 1; @(negedge clk); doneIrqReq = 0;
    busRead(A_STAT, v); chk("R6 irq flag", v, 32'h200);
    chk("R6 irqOut high", {31'b0, irqOut}, 1);
    busWrite(A_CTL, 32'h0);
    chk("R6 irqOut masked", {31'b0, irqOut}, 0);
    busWrite(A_STAT, 32'h0);
    busRead(A_STAT, v); chk("R7 write 0 keeps flag", v, 32'h200);
    busWrite(A_STAT, 32'h200);
    busRead(A_STAT, v); chk("R7 write 1 clears irq", v, 32'h0);
  endtask

  task automatic testErr();
    logic [31:0] v;
    @(negedge clk); errEvt = 1; @(negedge clk); errEvt = 0;
    busRead(A_STAT, v); chk("R8 no enable no latch", v, 32'h0);
    chk("R8 engStop low", {31'b0, engStop}, 0);
    busWrite(A_CTL, 32'h04);
    @(negedge clk); errEvt = 1; @(negedge clk); errEvt = 0;
    busRead(A_STAT, v); chk("R8 error latched", v, 32'h0A0);
    chk("R8 engStop high", {31'b0, engStop}, 1);
    busWrite(A_STAT, 32'h100);
    busRead(A_STAT, v); chk("R7 other bit clear no effect", v, 32'h0A0);
    busWrite(A_STAT, 32'h080);
    busRead(A_STAT, v); chk("R8 cleared", v, 32'h0);
    chk("R8 engStop released", {31'b0, engStop}, 0);
  endtask

  task automatic testEarly();
    logic [31:0] v;
    busWrite(A_CTL, 32'h0);
    @(negedge clk); earlyEvt = 1; @(negedge clk); earlyEvt = 0;
    busRead(A_STAT, v); chk("R9 no enable no latch", v, 32'h0);
    busWrite(A_CTL, 32'h08);
    @(negedge clk); earlyEvt = 1; @(negedge clk); earlyEvt = 0;
    busRead(A_STAT, v); chk("R9 early latched", v, 32'h120);
    chk("R9 engStop high", {31'b0, engStop}, 1);
    busWrite(A_STAT, 32'h100);
    busRead(A_STAT, v); chk("R9 cleared", v, 32'h0);
    busWrite(A_CTL, 32'h0);
  endtask

  task automatic testSeq();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rdDone = 1'b1;
      wrDone = (i % 2 == 0);
    end
    @(negedge clk); rdDone = 0; wrDone = 0;
    busRead(A_SEQ, v); chk("R10 seq counts", v, 32'h00030005);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    busWrite(A_CTL, 32'h10);
    @(negedge clk);
    doneIrqReq = 1; wrEn = 1; addr = A_STAT; wrData = 32'h200;
    @(negedge clk);
    doneIrqReq = 0; wrEn = 0;
    busRead(A_STAT, v); chk("R11 set beats clear", v, 32'h200);
    chk("R11 irqOut", {31'b0, irqOut}, 1);
    busWrite(A_STAT, 32'h200);
    busWrite(A_CTL, 32'h0);
  endtask

  task automatic testSoftReset();
    logic [31:0] v;
    int n;
    busWrite(A_CTL, 32'h14);
    busWrite(A_CTL, 32'h02);
    n = 0;
    while (engReset && n < 100) begin
      n++;
      wrEn = 0; rdDone = 0;
      if (n == 1) begin
        busRead(A_STAT, v); chk("R4 resetting flag", v, 32'h040);
        busRead(A_CTL, v);  chk("R4 ctl cleared", v, 32'h0);
        busRead(A_SEQ, v);  chk("R4 seq cleared", v, 32'h0);
      end
      if (n == 2) begin
        wrEn = 1; addr = A_CTL; wrData = 32'h10; rdDone = 1;
      end
      @(negedge clk);
    end
    wrEn = 0; rdDone = 0;
    chk("R4 window length", n, RST_N);
    busRead(A_CTL, v);  chk("R5 write ignored in reset", v, 32'h0);
    busRead(A_SEQ, v);  chk("R10 done ignored in reset", v, 32'h0);
    busRead(A_STAT, v); chk("R4 resetting dropped", v, 32'h0);
    busWrite(A_CTL, 32'h10);
    busRead(A_CTL, v);  chk("R5 write accepted after reset", v, 32'h10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testLive();
    testCtl();
    testIrq();
    testErr();
    testEarly();
    testSeq();
    testSetWins();
    testSoftReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule